// File: doc/BRIEF.md
# Dual-Channel Two-Cycle Transfer Engine

This block moves data on its own, without a processor in the loop. It has two channels. Each channel keeps a 20-bit read pointer, a 20-bit write pointer, a 16-bit transfer counter and a control byte. Software fills these in through a narrow write-only configuration port. Once a channel is enabled, holds a non-zero count, and has its peripheral request line high, the engine runs one transfer for it. A transfer is two bus cycles. The first reads from the read pointer and keeps the returned data in an internal holding register. The second writes that data to the write pointer.

Both endpoints carry their own memory/I/O space bit, so any pairing is legal: memory to memory, memory to I/O, I/O to memory, and I/O to I/O. Each pointer can count up, count down or stay fixed, in byte or word steps. When the counter runs out, the channel disables itself and raises a one-cycle completion pulse on its own output. Channel 0 has fixed priority over channel 1. A transfer that has started always finishes before the engine picks a channel again.

Top module: `dma2ch_engine`

## Requirements
- R1: After reset, bus_req and done are low and both channels are disabled, so request lines that are high cause no bus activity.
- R2: A configuration write selects a channel with cfg_ch and a field with cfg_sel. The field codes are 0 read pointer (20 bits), 1 write pointer (20 bits), 2 count (low 16 bits) and 3 control (low 8 bits). The control bits are: bit0 enable, bit1 word size, bit2 read side is I/O, bit3 write side is I/O, bits5:4 read pointer step, bits7:6 write pointer step. Step code 01 counts up, 10 counts down, and 00 or 11 holds.
- R3: Each transfer is a read cycle at the read pointer (bus_we=0) followed directly by a write cycle at the write pointer (bus_we=1). The write cycle drives the data returned by the read. bus_io gives the space of the side being accessed, and bus_word gives the channel's size.
- R4: While bus_req is high and bus_ready is low, bus_req, bus_addr, bus_we, bus_io and bus_word stay unchanged. A cycle ends on the first clock edge where bus_ready is high.
- R5: After each completed write, each pointer moves by its step code: by 1 for byte size and by 2 for word size, wrapping modulo 2^20.
- R6: The count drops by one on each completed write. The write that brings the count to zero also clears the channel's enable. That channel's done bit is then high for exactly the one cycle after the final write's ready edge.
- R7: When both channels are eligible at the same decision point, channel 0 runs first. A transfer in progress is never pre-empted: its write completes before any other channel's read starts.
- R8: A channel with enable clear, with count zero, or with its request line low starts no transfer. Its settings are kept until it becomes eligible.
- R9: Configuration writes aimed at the channel whose transfer is currently on the bus are ignored.
- R10: After every completed write, bus_req is low for at least one cycle before the next read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_sel | input | 2 | Field selector (0 read ptr, 1 write ptr, 2 count, 3 control) |
| cfg_wdata | input | 20 | Configuration write data |
| dreq | input | 2 | Per-channel transfer request, level sensitive |
| bus_req | output | 1 | A bus cycle is in progress |
| bus_addr | output | 20 | Bus cycle address |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_io | output | 1 | 1 selects I/O space, 0 memory |
| bus_word | output | 1 | 1 for a 16-bit transfer, 0 for a byte |
| bus_wdata | output | 16 | Write data (held data from the read cycle) |
| bus_rdata | input | 16 | Read data, sampled when bus_ready is high on a read |
| bus_ready | input | 1 | Completes the current bus cycle |
| done | output | 2 | One-cycle completion pulse per channel |

## Verification
Two cases can land on the same cycle. In the first, a configuration write to a channel arrives while that same channel's transfer is waiting on the bus. The bench provokes this by stretching the read with fixed wait states and rewriting the read pointer and control byte during the wait. The result is judged by whether the next transfer still reads from the old pointer plus its step. In the second, the higher-priority request rises while the lower channel is mid-transfer. The recorded bus trace must show the lower channel's write finishing before the higher channel's read. Constrained-random runs with random wait states compare every logged bus cycle and completion pulse against bench-computed pointer sequences.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_st_e;

    localparam logic [1:0] SEL_RPTR = 2'd0;
    localparam logic [1:0] SEL_WPTR = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam logic [1:0] STEP_UP   = 2'b01;
    localparam logic [1:0] STEP_DOWN = 2'b10;

    // control byte, bit0 first: en, word, rd_io, wr_io, rd_step, wr_step
    typedef struct packed {
        logic [1:0] wr_step;
        logic [1:0] rd_step;
        logic       wr_io;
        logic       rd_io;
        logic       word;
        logic       en;
    } chan_ctrl_t;

endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
    import dma2ch_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          locked,
    input  logic          xfer_done,
    input  logic          dreq,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] wr_ptr,
    output chan_ctrl_t    ctrl,
    output logic          eligible,
    output logic          done_pulse
);

    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [AW-1:0] wptr;
        logic [CW-1:0] cnt;
        chan_ctrl_t    ctrl;
        logic          done;
    } chan_regs_t;

    chan_regs_t r_d, r_q;

    function automatic logic [AW-1:0] nudge(input logic [AW-1:0] a,
                                            input logic [1:0]    mode,
                                            input logic          wide);
        logic [AW-1:0] amt;
        amt = wide ? AW'(2) : AW'(1);
        case (mode)
            STEP_UP:   return a + amt;
            STEP_DOWN: return a - amt;
            default:   return a;
        endcase
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (wr_en && !locked) begin
            case (wr_sel)
                SEL_RPTR: r_d.rptr = wr_data;
                SEL_WPTR: r_d.wptr = wr_data;
                SEL_CNT:  r_d.cnt  = wr_data[CW-1:0];
                default:  r_d.ctrl = chan_ctrl_t'(wr_data[7:0]);
            endcase
        end
        if (xfer_done) begin
            r_d.rptr = nudge(r_q.rptr, r_q.ctrl.rd_step, r_q.ctrl.word);
            r_d.wptr = nudge(r_q.wptr, r_q.ctrl.wr_step, r_q.ctrl.word);
            r_d.cnt  = r_q.cnt - CW'(1);
            if (r_q.cnt == CW'(1)) begin
                r_d.ctrl.en = 1'b0;
                r_d.done    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_ptr     = r_q.rptr;
    assign wr_ptr     = r_q.wptr;
    assign ctrl       = r_q.ctrl;
    assign eligible   = r_q.ctrl.en && (r_q.cnt != '0) && dreq;
    assign done_pulse = r_q.done;

endmodule

// File: rtl/dma2ch_arb.sv
module dma2ch_arb #(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] pick
);

    // lowest index wins
    always_comb begin
        any  = |req;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) pick = CHW'(i);
        end
    end

endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
    import dma2ch_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic [NCH-1:0] dreq,
    output logic           bus_req,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_we,
    output logic           bus_io,
    output logic           bus_word,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ready,
    output logic [NCH-1:0] done
);

    typedef struct packed {
        seq_st_e        st;
        logic [CHW-1:0] cur;
        logic [DW-1:0]  hold;
    } seq_t;

    seq_t s_d, s_q;

    logic [AW-1:0]  rptr_a [NCH];
    logic [AW-1:0]  wptr_a [NCH];
    chan_ctrl_t     ctrl_a [NCH];
    logic [NCH-1:0] elig;
    logic           any_elig;
    logic [CHW-1:0] pick;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma2ch_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (cfg_wr && (cfg_ch == CHW'(g))),
            .wr_sel     (cfg_sel),
            .wr_data    (cfg_wdata),
            .locked     ((s_q.st != ST_IDLE) && (s_q.cur == CHW'(g))),
            .xfer_done  ((s_q.st == ST_WR) && bus_ready && (s_q.cur == CHW'(g))),
            .dreq       (dreq[g]),
            .rd_ptr     (rptr_a[g]),
            .wr_ptr     (wptr_a[g]),
            .ctrl       (ctrl_a[g]),
            .eligible   (elig[g]),
            .done_pulse (done[g])
        );
    end

    dma2ch_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .req  (elig),
        .any  (any_elig),
        .pick (pick)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (any_elig) begin
                    s_d.st  = ST_RD;
                    s_d.cur = pick;
                end
            end
            ST_RD: begin
                if (bus_ready) begin
                    s_d.hold = bus_rdata;
                    s_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (bus_ready) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cur: '0, hold: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_req   = (s_q.st != ST_IDLE);
        bus_we    = (s_q.st == ST_WR);
        bus_addr  = bus_we ? wptr_a[s_q.cur] : rptr_a[s_q.cur];
        bus_io    = bus_we ? ctrl_a[s_q.cur].wr_io : ctrl_a[s_q.cur].rd_io;
        bus_word  = ctrl_a[s_q.cur].word;
        bus_wdata = s_q.hold;
    end

endmodule

// File: rtl/dma2ch_checker.sv
module dma2ch_checker #(
    parameter int NCH = 2,
    parameter int AW  = 20,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_we,
    input logic           bus_io,
    input logic           bus_word,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic           bus_ready,
    input logic [NCH-1:0] done
);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                     && $stable(bus_io) && $stable(bus_word)));

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready) |=> (bus_req && bus_we));

    assert_write_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready) |=> (bus_wdata == $past(bus_rdata)));

    assert_idle_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ready) |=> !bus_req);

    assert_done_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    assert_done_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> $past(bus_req && bus_we && bus_ready));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> !(|done));

endmodule

bind dma2ch_engine dma2ch_checker #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dma2ch_engine_bench.sv
module dma2ch_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [19:0] cfg_wdata = '0;
    logic [1:0]  dreq = '0;
    logic        bus_req, bus_we, bus_io, bus_word;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic [1:0]  done;

    always #4 clk = ~clk;

    dma2ch_engine u_dma2ch_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_io(bus_io), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .done(done)
    );

    int checks = 0;
    int fails = 0;
    int fixed_wait = -1;

    // bus trace
    logic [19:0] log_addr [256];
    logic        log_we   [256];
    logic        log_io   [256];
    logic        log_word [256];
    logic [15:0] log_data [256];
    int          log_n = 0;
    logic [19:0] exp_addr [256];
    logic        exp_we   [256];
    logic        exp_io   [256];
    logic        exp_word [256];
    logic [15:0] exp_data [256];
    int          exp_n = 0;

    int done_cnt [2];
    int done_bad = 0;
    int r4_bad = 0;
    int r10_bad = 0;
    int r10_obs = 0;

    function automatic logic [15:0] rd_fn(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h3C5};
    endfunction

    function automatic logic [19:0] step_fn(input logic [19:0] a, input logic [1:0] m,
                                            input logic w);
        logic [19:0] amt;
        amt = w ? 20'd2 : 20'd1;
        if (m == 2'b01) return a + amt;
        if (m == 2'b10) return a - amt;
        return a;
    endfunction

    function automatic logic [19:0] ctrl_fn(input logic en, input logic w, input logic rio,
                                            input logic wio, input logic [1:0] rs,
                                            input logic [1:0] ws);
        return {12'd0, ws, rs, wio, rio, w, en};
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // bus responder and monitor
    initial begin
        int wl;
        logic in_cyc;
        logic wr_prev;
        logic [19:0] h_addr;
        logic h_we;
        wl = 0; in_cyc = 1'b0; wr_prev = 1'b0; h_addr = '0; h_we = 1'b0;
        done_cnt[0] = 0; done_cnt[1] = 0;
        void'($urandom(32'd1234));
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bus_ready = 1'b0; in_cyc = 1'b0; wr_prev = 1'b0;
            end else begin
                for (int c = 0; c < 2; c++) begin
                    if (done[c]) begin
                        done_cnt[c]++;
                        if (!wr_prev) done_bad++;
                    end
                end
                if (wr_prev) begin
                    r10_obs++;
                    if (bus_req) r10_bad++;
                end
                wr_prev = 1'b0;
                if (bus_req) begin
                    if (!in_cyc) begin
                        in_cyc = 1'b1;
                        wl = (fixed_wait >= 0) ? fixed_wait : int'($urandom_range(0, 3));
                        h_addr = bus_addr; h_we = bus_we;
                    end else if (bus_addr !== h_addr || bus_we !== h_we) begin
                        r4_bad++;
                    end
                    bus_rdata = rd_fn(bus_addr);
                    if (wl == 0) begin
                        bus_ready = 1'b1;
                        in_cyc = 1'b0;
                        if (log_n < 256) begin
                            log_addr[log_n] = bus_addr; log_we[log_n] = bus_we;
                            log_io[log_n] = bus_io; log_word[log_n] = bus_word;
                            log_data[log_n] = bus_we ? bus_wdata : rd_fn(bus_addr);
                            log_n++;
                        end
                        if (bus_we) wr_prev = 1'b1;
                    end else begin
                        bus_ready = 1'b0;
                        wl--;
                    end
                end else begin
                    bus_ready = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1..watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic cfg(input int ch, input logic [1:0] sel, input logic [19:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_ch = 1'(ch); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [19:0] rp, input logic [19:0] wp,
                        input logic [15:0] n, input logic [19:0] c);
        cfg(ch, 2'd0, rp);
        cfg(ch, 2'd1, wp);
        cfg(ch, 2'd2, {4'd0, n});
        cfg(ch, 2'd3, c);
    endtask

    task automatic add_exp(input logic [19:0] rp, input logic [19:0] wp, input int n,
                           input logic [19:0] c);
        logic [19:0] s, d;
        s = rp; d = wp;
        for (int i = 0; i < n; i++) begin
            exp_addr[exp_n] = s; exp_we[exp_n] = 1'b0; exp_io[exp_n] = c[2];
            exp_word[exp_n] = c[1]; exp_data[exp_n] = rd_fn(s); exp_n++;
            exp_addr[exp_n] = d; exp_we[exp_n] = 1'b1; exp_io[exp_n] = c[3];
            exp_word[exp_n] = c[1]; exp_data[exp_n] = rd_fn(s); exp_n++;
            s = step_fn(s, c[5:4], c[1]);
            d = step_fn(d, c[7:6], c[1]);
        end
    endtask

    task automatic clear_logs();
        log_n = 0; exp_n = 0;
    endtask

    task automatic wait_log(input int n);
        int t;
        t = 0;
        while (log_n < n && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        chk(log_n == exp_n, {tag, " trace length"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_addr[i] == exp_addr[i] && log_we[i] == exp_we[i] &&
                log_io[i] == exp_io[i] && log_word[i] == exp_word[i] &&
                log_data[i] == exp_data[i], {tag, " bus cycle"},
                {log_we[i], log_io[i], log_word[i], log_addr[i], log_data[i]},
                {exp_we[i], exp_io[i], exp_word[i], exp_addr[i], exp_data[i]});
        end
    endtask

    initial begin
        int d0, d1;
        logic [19:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset, channels disabled
        chk(bus_req == 1'b0 && done == 2'b00, "R1 reset outputs", {bus_req, done}, 0);
        dreq = 2'b11;
        repeat (20) @(negedge clk);
        chk(log_n == 0, "R1 no activity when disabled", log_n, 0);
        dreq = 2'b00;

        // R3 R5 R6: word mem->io, both up
        clear_logs();
        c = ctrl_fn(1, 1, 0, 1, 2'b01, 2'b01);
        prog(0, 20'h01000, 20'h00200, 16'd3, c);
        add_exp(20'h01000, 20'h00200, 3, c);
        d0 = done_cnt[0];
        dreq = 2'b01;
        wait_log(exp_n);
        compare("R3 R5 word up");
        chk(done_cnt[0] == d0 + 1, "R6 one done pulse ch0", done_cnt[0] - d0, 1);
        repeat (20) @(negedge clk);
        chk(log_n == exp_n, "R6 enable cleared at zero count", log_n, exp_n);
        dreq = 2'b00;

        // R5: byte io->io, read down, write hold, wrap through zero
        clear_logs();
        c = ctrl_fn(1, 0, 1, 1, 2'b10, 2'b00);
        prog(1, 20'h00001, 20'h0F0F0, 16'd4, c);
        add_exp(20'h00001, 20'h0F0F0, 4, c);
        d1 = done_cnt[1];
        dreq = 2'b10;
        wait_log(exp_n);
        compare("R5 byte down wrap");
        chk(done_cnt[1] == d1 + 1, "R6 one done pulse ch1", done_cnt[1] - d1, 1);
        dreq = 2'b00;

        // R7: both eligible together, channel 0 first
        clear_logs();
        c = ctrl_fn(1, 1, 0, 0, 2'b01, 2'b10);
        prog(0, 20'h20000, 20'h30000, 16'd2, c);
        add_exp(20'h20000, 20'h30000, 2, c);
        c = ctrl_fn(1, 0, 1, 0, 2'b00, 2'b01);
        prog(1, 20'h00400, 20'h40000, 16'd2, c);
        add_exp(20'h00400, 20'h40000, 2, c);
        dreq = 2'b11;
        wait_log(exp_n);
        compare("R7 fixed priority");
        dreq = 2'b00;

        // R7: channel 1 in flight when channel 0 requests
        clear_logs();
        fixed_wait = 3;
        c = ctrl_fn(1, 1, 0, 0, 2'b01, 2'b01);
        prog(1, 20'h50000, 20'h60000, 16'd1, c);
        add_exp(20'h50000, 20'h60000, 1, c);
        prog(0, 20'h70000, 20'h80000, 16'd1, c);
        add_exp(20'h70000, 20'h80000, 1, c);
        dreq = 2'b10;
        while (!bus_req) @(negedge clk);
        dreq = 2'b11;
        wait_log(exp_n);
        compare("R7 no preemption");
        dreq = 2'b00;

        // R9: rewrites to active channel are dropped
        clear_logs();
        fixed_wait = 8;
        c = ctrl_fn(1, 1, 0, 0, 2'b01, 2'b01);
        prog(0, 20'h0A000, 20'h0B000, 16'd2, c);
        add_exp(20'h0A000, 20'h0B000, 2, c);
        dreq = 2'b01;
        while (!bus_req) @(negedge clk);
        cfg(0, 2'd0, 20'h12345);
        cfg(0, 2'd3, 20'h0);
        wait_log(exp_n);
        compare("R9 locked config");
        dreq = 2'b00;
        fixed_wait = -1;

        // R8: count zero, disabled, and request low
        clear_logs();
        c = ctrl_fn(1, 0, 0, 0, 2'b01, 2'b01);
        prog(0, 20'h00010, 20'h00020, 16'd0, c);
        dreq = 2'b01;
        repeat (30) @(negedge clk);
        chk(log_n == 0, "R8 count zero idle", log_n, 0);
        cfg(0, 2'd3, ctrl_fn(0, 0, 0, 0, 2'b01, 2'b01));
        cfg(0, 2'd2, 20'd3);
        repeat (30) @(negedge clk);
        chk(log_n == 0, "R8 disabled idle", log_n, 0);
        dreq = 2'b00;
        cfg(0, 2'd3, c);
        repeat (30) @(negedge clk);
        chk(log_n == 0, "R8 request low idle", log_n, 0);
        add_exp(20'h00010, 20'h00020, 3, c);
        dreq = 2'b01;
        wait_log(exp_n);
        compare("R8 R2 resumes with kept setup");
        dreq = 2'b00;

        // R2 R3 R5 R6: constrained random runs
        for (int it = 0; it < 12; it++) begin
            int ch, n;
            logic [19:0] rp, wp;
            clear_logs();
            ch = int'($urandom_range(0, 1));
            n = int'($urandom_range(1, 5));
            rp = 20'($urandom);
            wp = 20'($urandom);
            c = ctrl_fn(1, 1'($urandom), 1'($urandom), 1'($urandom),
                        2'($urandom), 2'($urandom));
            prog(ch, rp, wp, 16'(n), c);
            add_exp(rp, wp, n, c);
            d0 = done_cnt[ch];
            dreq = (ch == 0) ? 2'b01 : 2'b10;
            wait_log(exp_n);
            compare("R2 R3 R5 random");
            chk(done_cnt[ch] == d0 + 1, "R6 random done", done_cnt[ch] - d0, 1);
            dreq = 2'b00;
        end

        chk(r4_bad == 0, "R4 controls held through waits", r4_bad, 0);
        chk(r10_bad == 0 && r10_obs > 0, "R10 idle gap after write", r10_bad, 0);
        chk(done_bad == 0, "R6 done timing", done_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule